// File: doc/BRIEF.md
# Low-Power Lane Mode Request Detector

This block watches the two single-ended wires of a serial data lane while the lane is in its low-power control phase. The lane carries four low-power states, written LP-xy, where x is the level of the positive wire and y the level of the negative wire. LP-11 is the stop state. From the stop state a transmitter asks for a change of operating mode by walking the wires through a short, fixed chain of states. The detector recognises these chains and raises a one-cycle pulse naming the request.

Three chains are recognised:

- High-speed entry is LP-11, LP-01, LP-00.
- Escape entry is LP-11, LP-10, LP-00, LP-01, LP-00.
- Turnaround is LP-11, LP-10, LP-00, LP-10, LP-00.

Escape and turnaround share their first three states, so they are told apart only at the fourth. The wires are assumed to be synchronised to `clk` already.

Before a wire state counts as a step, it must have been sampled unchanged for `STABLE_CYC` consecutive clock edges. This keeps short glitches out of the sequence. A step that does not fit any chain aborts the attempt and raises an error pulse. After an error or a recognised request, the detector ignores the lane until LP-11 is accepted again.

Top module: `lp_req_detect`

## Requirements
- R1: While `rst_n` is low at a clock edge, the detector resets. After that edge, all pulse outputs are low and `in_stop` is high, because the accepted state is LP-11 and the detector is armed.
- R2: The wire state is the 2-bit value {`line_p`,`line_n`}, for example 2'b10 is LP-10. A new value is accepted as a step at the first clock edge after it has been sampled on `STABLE_CYC` consecutive edges, provided it differs from the currently accepted state. A value held for fewer edges produces no step and has no effect on any output.
- R3: When armed, the accepted steps LP-10, LP-00, LP-01, LP-00 make `esc_req` high for exactly one cycle. That cycle follows the edge at which the last LP-00 is accepted.
- R4: When armed, the accepted steps LP-01, LP-00 make `hs_req` high for exactly one cycle, in the cycle after the LP-00 is accepted.
- R5: When armed, the accepted steps LP-10, LP-00, LP-10, LP-00 make `turn_req` high for exactly one cycle, in the cycle after the last LP-00 is accepted.
- R6: When armed, an accepted step that is not the expected next step of any request makes `seq_err` high for one cycle and abandons the attempt. If that step is LP-11 the detector is re-armed at once; otherwise it stays disarmed.
- R7: `in_stop` is high exactly when the detector is armed and no step has been accepted since LP-11.
- R8: After a request pulse or an error, the detector produces no further pulses until LP-11 is accepted. The LP-11 step itself re-arms the detector without a pulse.
- R9: At most one of `esc_req`, `hs_req`, `turn_req` and `seq_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_p | input | 1 | Synchronised level of the positive wire |
| line_n | input | 1 | Synchronised level of the negative wire |
| esc_req | output | 1 | One-cycle escape entry request |
| hs_req | output | 1 | One-cycle high-speed entry request |
| turn_req | output | 1 | One-cycle turnaround request |
| seq_err | output | 1 | One-cycle sequence error |
| in_stop | output | 1 | Armed in the stop state |

## Verification
The assertions take for granted that both wire inputs are already synchronous to `clk` and settle between edges, and that `STABLE_CYC` is at least one. Under those conditions a requirement never needs more than one accepted step per edge. The bench changes the wires only on falling clock edges. Its hold times range from a single cycle to well past the stability window, so it drives glitches shorter than the window as well as proper steps. Both wires may change together, so every one of the four states can follow any other.

// File: rtl/lp_req_detect.sv
module lp_req_detect #(
  parameter int STABLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_p,
  input  logic line_n,
  output logic esc_req,
  output logic hs_req,
  output logic turn_req,
  output logic seq_err,
  output logic in_stop
);
  localparam int CW = $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(STABLE_CYC);
  localparam logic [1:0] LP00 = 2'b00, LP01 = 2'b01, LP10 = 2'b10, LP11 = 2'b11;

  typedef enum logic [2:0] {IDLE, STOP, GOT10, GOT1000, ESC01, TRN10, HS01} st_t;

  st_t st, nxt;
  logic [1:0] cand, acc;
  logic [CW-1:0] run;
  logic fire_e, fire_h, fire_t, bad;

  wire [1:0] smp  = {line_p, line_n};
  wire       take = (run >= RUN_MAX) && (cand != acc);

  assign in_stop = (st == STOP);

  always_comb begin
    nxt = st;
    fire_e = 1'b0;
    fire_h = 1'b0;
    fire_t = 1'b0;
    bad = 1'b0;
    if (take) begin
      case (st)
        STOP:    if (cand == LP10) nxt = GOT10;
                 else if (cand == LP01) nxt = HS01;
                 else bad = 1'b1;
        GOT10:   if (cand == LP00) nxt = GOT1000; else bad = 1'b1;
        GOT1000: if (cand == LP01) nxt = ESC01;
                 else if (cand == LP10) nxt = TRN10;
                 else bad = 1'b1;
        ESC01:   if (cand == LP00) begin fire_e = 1'b1; nxt = IDLE; end else bad = 1'b1;
        TRN10:   if (cand == LP00) begin fire_t = 1'b1; nxt = IDLE; end else bad = 1'b1;
        HS01:    if (cand == LP00) begin fire_h = 1'b1; nxt = IDLE; end else bad = 1'b1;
        default: if (cand == LP11) nxt = STOP;
      endcase
      if (bad) nxt = (cand == LP11) ? STOP : IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand     <= LP11;
      acc      <= LP11;
      run      <= RUN_MAX;
      st       <= STOP;
      esc_req  <= 1'b0;
      hs_req   <= 1'b0;
      turn_req <= 1'b0;
      seq_err  <= 1'b0;
    end else begin
      if (smp != cand) begin
        cand <= smp;
        run  <= CW'(1);
      end else if (run < RUN_MAX) begin
        run <= run + CW'(1);
      end
      if (take) acc <= cand;
      st       <= nxt;
      esc_req  <= fire_e;
      hs_req   <= fire_h;
      turn_req <= fire_t;
      seq_err  <= bad;
    end
  end
endmodule

// File: rtl/lp_req_detect_chk.sv
module lp_req_detect_chk #(
  parameter int STABLE_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic line_p,
  input logic line_n,
  input logic esc_req,
  input logic hs_req,
  input logic turn_req,
  input logic seq_err,
  input logic in_stop
);
  localparam int CW = $clog2(STABLE_CYC + 1);
  logic [1:0] last;
  logic [CW-1:0] rl;
  logic ok11;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last <= 2'b11;
      rl   <= CW'(STABLE_CYC);
      ok11 <= 1'b1;
    end else begin
      ok11 <= (last == 2'b11) && (rl >= CW'(STABLE_CYC));
      if ({line_p, line_n} != last) begin
        last <= {line_p, line_n};
        rl   <= CW'(1);
      end else if (rl < CW'(STABLE_CYC)) begin
        rl <= rl + CW'(1);
      end
    end
  end

  // R9
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({esc_req, hs_req, turn_req, seq_err}));
  // R3
  esc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    esc_req |=> !esc_req);
  // R4
  hs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_req |=> !hs_req);
  // R5
  turn_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    turn_req |=> !turn_req);
  // R8
  req_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_req || hs_req || turn_req) |-> !in_stop);
  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> !seq_err);
  // R2
  stop_needs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_stop) |-> ok11);
endmodule

bind lp_req_detect lp_req_detect_chk #(.STABLE_CYC(STABLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_p(line_p), .line_n(line_n),
  .esc_req(esc_req), .hs_req(hs_req), .turn_req(turn_req),
  .seq_err(seq_err), .in_stop(in_stop)
);

// File: tb/sim_lp_req_detect.sv
`timescale 1ns/1ps
module sim_lp_req_detect;
  localparam int STB = 4;
  logic clk = 1'b0, rst_n = 1'b0, line_p = 1'b1, line_n = 1'b1;
  logic esc_req, hs_req, turn_req, seq_err, in_stop;
  int checks = 0, fails = 0;
  int n_esc = 0, n_hs = 0, n_trn = 0, n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lp_req_detect #(.STABLE_CYC(STB)) u0 (
    .clk(clk), .rst_n(rst_n), .line_p(line_p), .line_n(line_n),
    .esc_req(esc_req), .hs_req(hs_req), .turn_req(turn_req),
    .seq_err(seq_err), .in_stop(in_stop)
  );

  // behavioural reference
  int run_val, run_len, acc_m;
  bit armed;
  int seq[$];
  bit x_e, x_h, x_t, x_err;

  function automatic bit is_prefix(int q[$], int p[$]);
    if (q.size() > p.size()) return 0;
    foreach (q[i]) if (q[i] != p[i]) return 0;
    return 1;
  endfunction

  task automatic step_model(int v);
    int pe[$] = '{2, 0, 1, 0};
    int pt[$] = '{2, 0, 2, 0};
    int ph[$] = '{1, 0};
    if (!armed) begin
      if (v == 3) begin armed = 1; seq.delete(); end
      return;
    end
    seq.push_back(v);
    if (seq == pe) begin x_e = 1; armed = 0; end
    else if (seq == pt) begin x_t = 1; armed = 0; end
    else if (seq == ph) begin x_h = 1; armed = 0; end
    else if (!is_prefix(seq, pe) && !is_prefix(seq, pt) && !is_prefix(seq, ph)) begin
      x_err = 1;
      armed = (v == 3);
      seq.delete();
    end
    if (!armed) seq.delete();
  endtask

  always @(posedge clk) begin
    x_e = 0; x_h = 0; x_t = 0; x_err = 0;
    if (!rst_n) begin
      run_val = 3; run_len = STB; acc_m = 3; armed = 1; seq.delete();
    end else begin
      int s;
      if (run_len >= STB && run_val != acc_m) begin
        acc_m = run_val;
        step_model(run_val);
      end
      s = int'({line_p, line_n});
      if (s == run_val) begin
        if (run_len < STB) run_len++;
      end else begin
        run_val = s; run_len = 1;
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 esc_req", esc_req, 1'b0);
      chk("R1 in_stop", in_stop, 1'b1);
      chk("R1 seq_err", seq_err, 1'b0);
    end else if (!finished) begin
      chk("R3 esc_req", esc_req, x_e);
      chk("R4 hs_req", hs_req, x_h);
      chk("R5 turn_req", turn_req, x_t);
      chk("R6 seq_err", seq_err, x_err);
      chk("R7 in_stop", in_stop, armed && seq.size() == 0);
      if (esc_req) n_esc++;
      if (hs_req) n_hs++;
      if (turn_req) n_trn++;
      if (seq_err) n_err++;
    end
  end

  task automatic hold(int v, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      {line_p, line_n} = v[1:0];
    end
  endtask

  task automatic walk(int a, int b, int c, int d, int e);
    hold(a, 6); hold(b, 6); hold(c, 6); hold(d, 6); hold(e, 6);
  endtask

  initial begin
    int cnt_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    walk(3, 2, 0, 1, 0);                 // R3 escape
    walk(3, 1, 0, 0, 0);                 // R4 high-speed
    walk(3, 2, 0, 2, 0);                 // R5 turnaround
    // R2 glitch shorter than window inside the high-speed chain
    hold(3, 6); hold(1, 6); hold(2, STB - 1); hold(1, 6); hold(0, 6);
    // R6 wrong step, then R8 no pulse while disarmed
    walk(3, 2, 1, 0, 1);
    cnt_before = n_hs + n_esc + n_trn;
    hold(0, 6); hold(1, 6); hold(0, 6);
    checks++;
    if (n_hs + n_esc + n_trn != cnt_before) begin
      fails++;
      $display("FAIL R8 pulses while disarmed: actual %0d expected %0d",
               n_hs + n_esc + n_trn, cnt_before);
    end
    // R6 abort by LP-11 re-arms at once, then R4
    hold(3, 6); hold(2, 6); hold(3, 6); hold(1, 6); hold(0, 6);
    for (int k = 0; k < 3000; k++) hold($urandom_range(0, 3), $urandom_range(1, 2 * STB));
    for (int k = 0; k < 200; k++) begin
      hold(3, STB + 1);
      case ($urandom_range(0, 2))
        0: walk(3, 2, 0, 1, 0);
        1: walk(3, 2, 0, 2, 0);
        default: walk(3, 1, 0, 3, 3);
      endcase
    end
    hold(3, 8);
    checks++;
    if (n_esc == 0) begin fails++; $display("FAIL R3 no escape seen: actual 0 expected >0"); end
    checks++;
    if (n_hs == 0) begin fails++; $display("FAIL R4 no high-speed seen: actual 0 expected >0"); end
    checks++;
    if (n_trn == 0) begin fails++; $display("FAIL R5 no turnaround seen: actual 0 expected >0"); end
    checks++;
    if (n_err == 0) begin fails++; $display("FAIL R6 no error seen: actual 0 expected >0"); end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule